// File: doc/BRIEF.md
# Asynchronous SRAM Write Controller

This block lets logic on a synchronous system clock write into an asynchronous static RAM that has a 16-bit data bus split into an upper and a lower byte lane. A requester presents an address, a data word and a per-lane byte mask together with a request. The controller captures them and runs the memory's chip-select, write-strobe, lane-select and output-enable lines through a fixed sequence of phases: setup, strobe, recover. It also drives a data-bus drive enable for the bidirectional pads.

Each phase lasts a whole number of clock cycles. That number is derived at elaboration from nanosecond-style timing minimums, given in picoseconds, and a clock period parameter. The rule is count = ceil(t / period) with a floor of one cycle. The memory commits a write only while chip-select, at least one lane select and the write strobe are all low. The controller always ends the write by raising the write strobe while the other selects are still low, so data setup and hold are measured against that single edge. Output-enable stays high for the whole cycle. This keeps the shorter write-strobe minimum in force and keeps the memory's outputs off the shared bus. The requester sees `ready` while the block is idle and a one-cycle `done` when a write completes.

Top module: `sram_wr_ctrl`

## Requirements
- R1: After reset `ready`=1 and `done`=0. All strobes are high: `mem_ce_n`, `mem_we_n`, `mem_oe_n` and every `mem_be_n` bit. `mem_dq_oe`=0.
- R2: `mem_we_n` is low only while `mem_ce_n` is low and at least one `mem_be_n` bit is low. When `mem_we_n` rises, `mem_ce_n` and the lane selects are still low, so the write strobe is the edge that ends every write.
- R3: Each low pulse of `mem_we_n` lasts at least T_WP_PS (cycles × CLK_PS). This is 5000 ps at the defaults, which give 2 cycles.
- R4: `mem_dq_oe` goes high only while `mem_we_n` is low, and no earlier than T_WZ_PS after its fall. It stays high for at least T_DS_PS before the rising edge of `mem_we_n`. It goes low on the same clock edge on which `mem_we_n` rises.
- R5: `mem_oe_n` is high at all times.
- R6: Successive falling edges of `mem_we_n` are at least T_WC_PS apart. `mem_addr` is stable for as long as `mem_ce_n` stays low.
- R7: Mask bit 1 selects the upper lane (`mem_be_n[1]` low, data bits 15:8). Mask bit 0 selects the lower lane (`mem_be_n[0]` low, data bits 7:0). During a write, `mem_be_n` equals the inverted mask.
- R8: A request whose mask is all zero still runs the full sequence and pulses `done`. It never drives `mem_we_n` low and never enables the data drivers.
- R9: A request is taken on a clock edge where `req`=1 and `ready`=1. `ready` is 0 from that edge until the write finishes. Requests and input changes while busy are ignored. `done` is a one-cycle pulse, C_SET+C_STB+C_REC cycles after acceptance (4 at the defaults). `ready` returns in the same cycle as `done`.
- R10: After any sequence of writes, each memory word holds the most recent data written to each of its lanes, and unselected lanes are left unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Write request |
| wr_addr | input | ADDR_W | Word address of the write |
| wr_data | input | DATA_W | Write data, one byte per lane |
| wr_mask | input | DATA_W/8 | Lane mask, 1 = write this lane |
| ready | output | 1 | Controller idle, request may be taken |
| done | output | 1 | One-cycle pulse at write completion |
| mem_addr | output | ADDR_W | Address to the memory |
| mem_dq_o | output | DATA_W | Data toward the bidirectional bus pads |
| mem_dq_oe | output | 1 | Drive enable for the data pads |
| mem_ce_n | output | 1 | Chip select, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_oe_n | output | 1 | Output enable, active low (held high) |
| mem_be_n | output | DATA_W/8 | Lane selects, active low |

## Verification
The hardest situation to reach is two writes that follow each other with no gap, so that the spacing between write-strobe edges is set by the sequence itself rather than by the requester. The bench reaches it by raising the next request in the very cycle that `done` appears. It also leaves `req` high with altered address and data during the busy window, to show that these are ignored. A behavioural memory model in the bench measures strobe overlap, pulse width, drive window and edge spacing at every write. It commits bytes only on the terminating strobe edge, so a wrong lane or a late driver shows up as wrong stored data.

// File: rtl/sram_wr_pkg.sv
package sram_wr_pkg;

   typedef enum logic [1:0] {
      ST_IDLE    = 2'd0,
      ST_SETUP   = 2'd1,
      ST_STROBE  = 2'd2,
      ST_RECOVER = 2'd3
   } wr_state_e;

   function automatic int imax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

   // whole clock cycles covering a time interval, never fewer than one
   function automatic int to_cycles(input int t_ps, input int clk_ps);
      return imax(1, (t_ps + clk_ps - 1) / clk_ps);
   endfunction

endpackage

// File: rtl/sram_wr_fsm.sv
module sram_wr_fsm
   import sram_wr_pkg::*;
#(
   parameter int C_SET = 1,
   parameter int C_STB = 2,
   parameter int C_REC = 1,
   parameter int C_HZ  = 1,
   parameter int CW    = 2
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      start,
   output wr_state_e st,
   output logic      drive_ok,
   output logic      ready,
   output logic      done
);

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st   <= ST_IDLE;
         cnt  <= '0;
         done <= 1'b0;
      end else begin
         done <= 1'b0;
         case (st)
            ST_IDLE: begin
               if (start) begin
                  st  <= ST_SETUP;
                  cnt <= '0;
               end
            end
            ST_SETUP: begin
               if (cnt == CW'(C_SET - 1)) begin
                  st  <= ST_STROBE;
                  cnt <= '0;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            ST_STROBE: begin
               if (cnt == CW'(C_STB - 1)) begin
                  st  <= ST_RECOVER;
                  cnt <= '0;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            default: begin
               if (cnt == CW'(C_REC - 1)) begin
                  st   <= ST_IDLE;
                  cnt  <= '0;
                  done <= 1'b1;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
         endcase
      end
   end

   assign ready    = (st == ST_IDLE);
   assign drive_ok = (st == ST_STROBE) && (cnt >= CW'(C_HZ));

endmodule

// File: rtl/sram_wr_capture.sv
module sram_wr_capture #(
   parameter int ADDR_W = 18,
   parameter int LANES  = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load,
   input  logic [ADDR_W-1:0]  addr_in,
   input  logic [LANES*8-1:0] data_in,
   input  logic [LANES-1:0]   mask_in,
   output logic [ADDR_W-1:0]  addr_q,
   output logic [LANES*8-1:0] data_q,
   output logic [LANES-1:0]   mask_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q <= '0;
         mask_q <= '0;
      end else if (load) begin
         addr_q <= addr_in;
         mask_q <= mask_in;
      end
   end

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            data_q[i*8 +: 8] <= '0;
         else if (load)
            data_q[i*8 +: 8] <= data_in[i*8 +: 8];
      end
   end

endmodule

// File: rtl/sram_wr_strobes.sv
module sram_wr_strobes
   import sram_wr_pkg::*;
#(
   parameter int LANES = 2
) (
   input  wr_state_e        st,
   input  logic             drive_ok,
   input  logic [LANES-1:0] mask_q,
   output logic             ce_n,
   output logic             we_n,
   output logic             oe_n,
   output logic             dq_oe,
   output logic [LANES-1:0] be_n
);

   logic any_lane;
   logic selected;

   assign any_lane = |mask_q;
   assign selected = (st != ST_IDLE);

   assign ce_n  = !selected;
   assign we_n  = !((st == ST_STROBE) && any_lane);
   assign oe_n  = 1'b1;
   assign dq_oe = drive_ok && any_lane;

   for (genvar i = 0; i < LANES; i++) begin : g_be
      assign be_n[i] = !(selected && mask_q[i]);
   end

endmodule

// File: rtl/sram_wr_ctrl.sv
module sram_wr_ctrl
   import sram_wr_pkg::*;
#(
   parameter int ADDR_W  = 18,
   parameter int DATA_W  = 16,
   parameter int CLK_PS  = 5000,
   parameter int T_WC_PS = 7000,
   parameter int T_CW_PS = 5000,
   parameter int T_AW_PS = 5000,
   parameter int T_BW_PS = 5000,
   parameter int T_WP_PS = 5000,
   parameter int T_DS_PS = 3500,
   parameter int T_WZ_PS = 3000
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                req,
   input  logic [ADDR_W-1:0]   wr_addr,
   input  logic [DATA_W-1:0]   wr_data,
   input  logic [DATA_W/8-1:0] wr_mask,
   output logic                ready,
   output logic                done,
   output logic [ADDR_W-1:0]   mem_addr,
   output logic [DATA_W-1:0]   mem_dq_o,
   output logic                mem_dq_oe,
   output logic                mem_ce_n,
   output logic                mem_we_n,
   output logic                mem_oe_n,
   output logic [DATA_W/8-1:0] mem_be_n
);

   localparam int LANES  = DATA_W / 8;
   localparam int C_HZ   = to_cycles(T_WZ_PS, CLK_PS);
   localparam int C_DS   = to_cycles(T_DS_PS, CLK_PS);
   localparam int C_STB  = imax(to_cycles(T_WP_PS, CLK_PS), C_HZ + C_DS);
   localparam int C_SEL  = imax(to_cycles(T_AW_PS, CLK_PS),
                               imax(to_cycles(T_CW_PS, CLK_PS), to_cycles(T_BW_PS, CLK_PS)));
   localparam int C_SET  = imax(1, C_SEL - C_STB);
   localparam int C_REC  = imax(1, to_cycles(T_WC_PS, CLK_PS) - C_STB - C_SET);
   localparam int C_MAX  = imax(C_SET, imax(C_STB, C_REC));
   localparam int CW     = imax(1, $clog2(C_MAX + 1));

   if (DATA_W < 8 || (DATA_W % 8) != 0) begin : g_bad_width
      $error("sram_wr_ctrl: DATA_W must be a positive multiple of 8");
   end
   if (CLK_PS <= 0) begin : g_bad_clk
      $error("sram_wr_ctrl: CLK_PS must be positive");
   end
   if (ADDR_W < 1) begin : g_bad_addr
      $error("sram_wr_ctrl: ADDR_W must be at least 1");
   end

   wr_state_e       st;
   logic            drive_ok;
   logic            start;
   logic [LANES-1:0] mask_q;

   assign start = req && ready;

   sram_wr_fsm #(
      .C_SET (C_SET),
      .C_STB (C_STB),
      .C_REC (C_REC),
      .C_HZ  (C_HZ),
      .CW    (CW)
   ) u_fsm (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .st       (st),
      .drive_ok (drive_ok),
      .ready    (ready),
      .done     (done)
   );

   sram_wr_capture #(
      .ADDR_W (ADDR_W),
      .LANES  (LANES)
   ) u_cap (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (start),
      .addr_in (wr_addr),
      .data_in (wr_data),
      .mask_in (wr_mask),
      .addr_q  (mem_addr),
      .data_q  (mem_dq_o),
      .mask_q  (mask_q)
   );

   sram_wr_strobes #(
      .LANES (LANES)
   ) u_stb (
      .st       (st),
      .drive_ok (drive_ok),
      .mask_q   (mask_q),
      .ce_n     (mem_ce_n),
      .we_n     (mem_we_n),
      .oe_n     (mem_oe_n),
      .dq_oe    (mem_dq_oe),
      .be_n     (mem_be_n)
   );

endmodule

// File: rtl/sram_wr_chk.sv
module sram_wr_chk #(
   parameter int ADDR_W  = 18,
   parameter int LANES   = 2,
   parameter int CLK_PS  = 5000,
   parameter int T_WC_PS = 7000,
   parameter int T_WP_PS = 5000
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ready,
   input logic              done,
   input logic              ce_n,
   input logic              we_n,
   input logic              oe_n,
   input logic              dq_oe,
   input logic [LANES-1:0]  be_n,
   input logic [ADDR_W-1:0] addr
);

   logic [7:0] since_fall;
   logic [7:0] low_len;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         since_fall <= 8'hFF;
         low_len    <= 8'd0;
      end else begin
         if (!we_n && low_len != 8'hFF)
            low_len <= low_len + 8'd1;
         else if (we_n)
            low_len <= 8'd0;
         if (!we_n && $past(we_n))
            since_fall <= 8'd1;
         else if (since_fall != 8'hFF)
            since_fall <= since_fall + 8'd1;
      end
   end

   // R5
   oe_high_chk: assert property (@(posedge clk) disable iff (!rst_n) oe_n);

   // R2
   we_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !we_n |-> (!ce_n && !(&be_n)));

   // R2
   we_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(we_n) |-> (!ce_n && !(&be_n)));

   // R4
   bus_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(we_n) |-> !dq_oe);

   // R4
   drive_inside_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dq_oe |-> !we_n);

   // R4
   hz_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(we_n) |-> !dq_oe);

   // R3
   pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(we_n) |-> (int'(low_len) * CLK_PS >= T_WP_PS));

   // R6
   cycle_time_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(we_n) |-> (int'(since_fall) * CLK_PS >= T_WC_PS));

   // R6
   addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ce_n && $past(!ce_n)) |-> $stable(addr));

   // R9
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R9
   ready_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ready |-> (ce_n && we_n));

endmodule

bind sram_wr_ctrl sram_wr_chk #(
   .ADDR_W  (ADDR_W),
   .LANES   (DATA_W / 8),
   .CLK_PS  (CLK_PS),
   .T_WC_PS (T_WC_PS),
   .T_WP_PS (T_WP_PS)
) u_chk (
   .clk   (clk),
   .rst_n (rst_n),
   .ready (ready),
   .done  (done),
   .ce_n  (mem_ce_n),
   .we_n  (mem_we_n),
   .oe_n  (mem_oe_n),
   .dq_oe (mem_dq_oe),
   .be_n  (mem_be_n),
   .addr  (mem_addr)
);

// File: tb/sim_sram_wr_ctrl.sv
`timescale 1ns/1ps
module sim_sram_wr_ctrl;

   localparam int AW     = 18;
   localparam int DW     = 16;
   localparam int CLK_PS = 5000;
   localparam int T_WC   = 7000;
   localparam int T_WP   = 5000;
   localparam int T_DS   = 3500;
   localparam int T_WZ   = 3000;
   // expected sequence length from acceptance to done, per R9 at defaults
   localparam int EXP_LAT = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req = 1'b0;
   logic [AW-1:0] wr_addr = '0;
   logic [DW-1:0] wr_data = '0;
   logic [1:0]    wr_mask = '0;
   logic          ready, done, mem_dq_oe, mem_ce_n, mem_we_n, mem_oe_n;
   logic [AW-1:0] mem_addr;
   logic [DW-1:0] mem_dq_o;
   logic [1:0]    mem_be_n;

   always #2.5 clk = ~clk;

   sram_wr_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .req(req), .wr_addr(wr_addr), .wr_data(wr_data),
      .wr_mask(wr_mask), .ready(ready), .done(done), .mem_addr(mem_addr),
      .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe), .mem_ce_n(mem_ce_n),
      .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n), .mem_be_n(mem_be_n)
   );

   int n_tests = 0;
   int n_fail  = 0;
   bit finished = 1'b0;

   task automatic check(input bit ok, input string tag, input logic [31:0] act,
                        input logic [31:0] exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // behavioural memory model and interval monitor
   logic [15:0] mdl_mem [int];
   logic [15:0] exp_mem [int];
   int  falls = 0;
   int  cyc = 0;
   int  last_fall = -1000;
   int  low_n = 0;
   int  drv_n = 0;
   bit  prev_we = 1'b1;
   logic [15:0] d_lat;
   logic [1:0]  be_lat;
   logic [AW-1:0] a_fall;

   always @(negedge clk) begin
      cyc++;
      if (rst_n && !finished) begin
         if (prev_we && !mem_we_n) begin
            falls++;
            check(!mem_ce_n && mem_be_n != 2'b11, "R2 overlap at strobe fall",
                  {mem_ce_n, mem_be_n}, 0);
            check(mem_oe_n == 1'b1, "R5 oe high during write", mem_oe_n, 1);
            check((cyc - last_fall) * CLK_PS >= T_WC, "R6 write cycle spacing",
                  (cyc - last_fall) * CLK_PS, T_WC);
            last_fall = cyc;
            low_n = 0;
            drv_n = 0;
            a_fall = mem_addr;
         end
         if (!mem_we_n) begin
            if (mem_dq_oe) begin
               if (drv_n == 0)
                  check(low_n * CLK_PS >= T_WZ, "R4 drive after high-Z",
                        low_n * CLK_PS, T_WZ);
               drv_n++;
               d_lat  = mem_dq_o;
               be_lat = mem_be_n;
            end
            low_n++;
         end
         if (!prev_we && mem_we_n) begin
            check(low_n * CLK_PS >= T_WP, "R3 strobe pulse width", low_n * CLK_PS, T_WP);
            check(drv_n * CLK_PS >= T_DS, "R4 data setup", drv_n * CLK_PS, T_DS);
            check(!mem_dq_oe, "R4 bus released with strobe", mem_dq_oe, 0);
            check(!mem_ce_n && mem_be_n != 2'b11, "R2 strobe ends write",
                  {mem_ce_n, mem_be_n}, 0);
            check(mem_addr == a_fall, "R6 address stable", mem_addr, a_fall);
            begin
               logic [15:0] w;
               w = mdl_mem.exists(int'(a_fall)) ? mdl_mem[int'(a_fall)] : 16'h0;
               if (!be_lat[1]) w[15:8] = d_lat[15:8];
               if (!be_lat[0]) w[7:0]  = d_lat[7:0];
               mdl_mem[int'(a_fall)] = w;
            end
         end
         prev_we = mem_we_n;
      end
   end

   task automatic do_write(input logic [AW-1:0] a, input logic [15:0] d,
                           input logic [1:0] m);
      int lat;
      int f0;
      while (!ready) @(negedge clk);
      req = 1'b1; wr_addr = a; wr_data = d; wr_mask = m;
      f0 = falls;
      @(negedge clk);
      check(!ready, "R9 busy after accept", ready, 0);
      check(mem_be_n == ~m, "R7 lane select mapping", mem_be_n, ~m);
      check(!mem_ce_n, "R2 chip select in setup", mem_ce_n, 0);
      // garbage held on the inputs while busy must be ignored
      wr_addr = a ^ 18'h1; wr_data = ~d; wr_mask = ~m;
      lat = 0;
      do begin
         @(negedge clk);
         lat++;
         if (lat == 1) req = 1'b0;
      end while (!done && lat < 20);
      check(lat == EXP_LAT, "R9 done latency", lat, EXP_LAT);
      check(ready, "R9 ready with done", ready, 1);
      if (m == 2'b00) begin
         check(falls == f0, "R8 zero mask no strobe", falls - f0, 0);
      end else begin
         logic [15:0] w;
         check(falls == f0 + 1, "R2 one strobe per write", falls - f0, 1);
         w = exp_mem.exists(int'(a)) ? exp_mem[int'(a)] : 16'h0;
         if (m[1]) w[15:8] = d[15:8];
         if (m[0]) w[7:0]  = d[7:0];
         exp_mem[int'(a)] = w;
      end
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         n_tests++; n_fail++;
         $display("FAIL watchdog expired actual=0 expected=1");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin : main
      void'($urandom(32'h1c3d5));
      repeat (3) @(negedge clk);
      check(ready && !done, "R1 reset handshake", {ready, done}, 2'b10);
      check(mem_ce_n && mem_we_n && mem_oe_n && mem_be_n == 2'b11 && !mem_dq_oe,
            "R1 reset strobes", {mem_ce_n, mem_we_n, mem_oe_n, mem_be_n, mem_dq_oe}, 6'b111110);
      rst_n = 1'b1;
      @(negedge clk);
      check(ready, "R1 ready after reset", ready, 1);

      // directed cases
      do_write(18'h0, 16'hA55A, 2'b11);
      do_write(18'h3FFFF, 16'h1234, 2'b10);
      do_write(18'h0, 16'h00C3, 2'b01);
      do_write(18'h5, 16'hFFFF, 2'b00);
      check(!exp_mem.exists(5) && !mdl_mem.exists(5), "R8 zero mask leaves memory",
            mdl_mem.exists(5), 0);
      // back-to-back: next request in the done cycle
      do_write(18'h7, 16'hBEEF, 2'b11);
      do_write(18'h7, 16'h0011, 2'b10);
      @(negedge clk);
      check(!done, "R9 done is one cycle", done, 0);
      check(mem_oe_n, "R5 oe high when idle", mem_oe_n, 1);

      // constrained random
      for (int i = 0; i < 60; i++) begin
         logic [AW-1:0] a;
         int gap;
         a = ($urandom % 4 == 0) ? AW'($urandom) : AW'($urandom % 8);
         do_write(a, 16'($urandom), 2'($urandom % 4));
         gap = $urandom % 3;
         if (gap > 0) begin
            @(negedge clk);
            check(!done, "R9 done pulse ends", done, 0);
            repeat (gap - 1) @(negedge clk);
         end
      end

      repeat (3) @(negedge clk);
      foreach (exp_mem[k]) begin
         logic [15:0] got;
         got = mdl_mem.exists(k) ? mdl_mem[k] : 16'h0;
         check(got == exp_mem[k], "R10 stored word", got, exp_mem[k]);
      end
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule